// File: doc/BRIEF.md
# Microcoded Stack Machine Register Datapath

This block is the 32-bit register datapath of a microcoded stack processor. Each cycle a microinstruction selects one register onto a B-bus, picks an ALU function that combines it with the holding register H, may shift the result left by one byte, and writes that result into any subset of the C-bus registers at the next clock edge. Sign and zero flags of the ALU result are captured every cycle for the sequencer's conditional branches.

Memory traffic goes through three strobes. A data read or write is launched at the word address in the memory address register, and a program fetch reads one byte at the program counter. Each strobe is registered, so the access happens in the cycle after the request. Read data lands in the memory data register, and the fetched byte lands in the 8-bit instruction byte register, at the end of that cycle. The sequencer and the microcode store sit outside this block and drive its control inputs directly.

Top module: `stack_dp_core`

## Requirements
- R1: While reset is held, every output is zero: the data byte address, write data, program address, all three strobes and both flags.
- R2: The B-bus select code maps 0 to the data register, 1 to the program counter, 2 to the instruction byte sign-extended, 3 to the instruction byte zero-extended, 4 to the stack pointer, 5 to the local frame base, 6 to the constant base, 7 to the top-of-stack copy and 8 to the scratch register. Codes 9 to 15 put zero on the bus.
- R3: The ALU operation code selects 0 H+B, 1 B-H, 2 H AND B, 3 H OR B, 4 B+1, 5 B-1, 6 H+B+1, 7 B. H is the only A-side operand.
- R4: When the shift control is high, the ALU result is shifted left by 8 bits before it reaches the C-bus and the flags.
- R5: The 9-bit C-bus write mask has bit 0 address, 1 data, 2 program counter, 3 stack pointer, 4 local base, 5 constant base, 6 top-of-stack, 7 scratch, 8 H. All set bits load the same result at one edge. Registers whose bit is clear keep their value.
- R6: The data byte address output is the address register shifted left by 2.
- R7: A read request raises the read strobe in the next cycle, at the address the register holds after the request edge. The returned word is loaded into the data register at the end of that cycle.
- R8: A write request raises the write strobe in the next cycle. The write data output is the data register as updated at the request edge.
- R9: A fetch request raises the fetch strobe in the next cycle, with the program address equal to the updated program counter. The returned byte is loaded into the instruction byte register at the end of that cycle.
- R10: The negative flag and the zero flag hold bit 31 of the final result, and whether that result equals zero, from the previous cycle.
- R11: When a C-bus write to the data register and a returning read coincide at the same edge, the C-bus value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bsel_i | input | 4 | B-bus source code |
| alu_op_i | input | 3 | ALU function code |
| shl8_i | input | 1 | Shift the result left by one byte |
| cwr_i | input | 9 | C-bus write mask |
| rd_i | input | 1 | Request a data read |
| wr_i | input | 1 | Request a data write |
| fetch_i | input | 1 | Request a program byte fetch |
| mem_rdata_i | input | 32 | Data word returned while the read strobe is high |
| prog_byte_i | input | 8 | Program byte returned while the fetch strobe is high |
| mem_addr_o | output | 32 | Data byte address |
| mem_wdata_o | output | 32 | Data register contents |
| mem_rd_o | output | 1 | Data read strobe |
| mem_wr_o | output | 1 | Data write strobe |
| prog_addr_o | output | 32 | Program byte address |
| prog_rd_o | output | 1 | Program fetch strobe |
| n_o | output | 1 | Latched negative flag |
| z_o | output | 1 | Latched zero flag |

## Verification
The checks assume that the sequencer never asks for a read and a write in the same microinstruction, since both would use the one address register. One property watches that input condition. The directed tasks each issue at most one memory request per cycle, and they leave a full idle cycle after every read before they look at the data register. The memory model answers in the same cycle as the strobe, which matches the one-cycle return timing that the data and instruction byte registers expect.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  localparam int DATA_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 4;
  localparam int OP_W    = 3;
  localparam int WORD_SH = 2;
  localparam int IDX_SH  = 8;

  typedef enum logic [SEL_W-1:0] {
    BS_MDR  = 4'd0,
    BS_PC   = 4'd1,
    BS_MBRS = 4'd2,
    BS_MBRU = 4'd3,
    BS_SP   = 4'd4,
    BS_LV   = 4'd5,
    BS_CPP  = 4'd6,
    BS_TOS  = 4'd7,
    BS_OPC  = 4'd8
  } bsrc_e;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_BSUB = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_INCB = 3'd4,
    OP_DECB = 3'd5,
    OP_ADD1 = 3'd6,
    OP_PASS = 3'd7
  } aluop_e;

  localparam int C_MAR = 0;
  localparam int C_MDR = 1;
  localparam int C_PC  = 2;
  localparam int C_SP  = 3;
  localparam int C_LV  = 4;
  localparam int C_CPP = 5;
  localparam int C_TOS = 6;
  localparam int C_OPC = 7;
  localparam int C_H   = 8;
  localparam int CW    = 9;

endpackage

// File: rtl/sdp_rst_sync.sv
module sdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/sdp_bbus_mux.sv
module sdp_bbus_mux
  import sdp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    mdr,
  input  logic [DW-1:0]    pc,
  input  logic [BW-1:0]    mbr,
  input  logic [DW-1:0]    sp,
  input  logic [DW-1:0]    lv,
  input  logic [DW-1:0]    cpp,
  input  logic [DW-1:0]    tos,
  input  logic [DW-1:0]    opc,
  output logic [DW-1:0]    bus
);
  localparam int EXT_W = DW - BW;

  logic [DW-1:0] mbr_sx;
  logic [DW-1:0] mbr_zx;

  assign mbr_sx = {{EXT_W{mbr[BW-1]}}, mbr};
  assign mbr_zx = {{EXT_W{1'b0}}, mbr};

  always_comb begin
    unique case (sel)
      BS_MDR:  bus = mdr;
      BS_PC:   bus = pc;
      BS_MBRS: bus = mbr_sx;
      BS_MBRU: bus = mbr_zx;
      BS_SP:   bus = sp;
      BS_LV:   bus = lv;
      BS_CPP:  bus = cpp;
      BS_TOS:  bus = tos;
      BS_OPC:  bus = opc;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/sdp_alu.sv
module sdp_alu
  import sdp_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int SHAMT = IDX_SH
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [OP_W-1:0] op,
  input  logic            shl,
  output logic [DW-1:0]   y,
  output logic            neg,
  output logic            zero
);
  logic [DW-1:0] raw;

  always_comb begin
    unique case (op)
      OP_ADD:  raw = a + b;
      OP_BSUB: raw = b - a;
      OP_AND:  raw = a & b;
      OP_OR:   raw = a | b;
      OP_INCB: raw = b + DW'(1);
      OP_DECB: raw = b - DW'(1);
      OP_ADD1: raw = a + b + DW'(1);
      default: raw = b;
    endcase
  end

  assign y    = shl ? (raw << SHAMT) : raw;
  assign neg  = y[DW-1];
  assign zero = (y == '0);
endmodule

// File: rtl/stack_dp_core.sv
module stack_dp_core
  import sdp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bsel_i,
  input  logic [OP_W-1:0]   alu_op_i,
  input  logic              shl8_i,
  input  logic [CW-1:0]     cwr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              fetch_i,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic [BW-1:0]     prog_byte_i,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DW-1:0]     prog_addr_o,
  output logic              prog_rd_o,
  output logic              n_o,
  output logic              z_o
);
  logic          rst_sn;
  logic [DW-1:0] creg_q [CW];
  logic [DW-1:0] creg_d [CW];
  logic [CW-1:0] creg_en;
  logic [BW-1:0] mbr_q, mbr_d;
  logic          mbr_en;
  logic          rd_q, wr_q, fetch_q;
  logic          n_q, z_q;
  logic [DW-1:0] b_bus, c_bus;
  logic          alu_n, alu_z;

  sdp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  sdp_bbus_mux #(.DW(DW), .BW(BW)) u_bmux (
    .sel (bsel_i),
    .mdr (creg_q[C_MDR]),
    .pc  (creg_q[C_PC]),
    .mbr (mbr_q),
    .sp  (creg_q[C_SP]),
    .lv  (creg_q[C_LV]),
    .cpp (creg_q[C_CPP]),
    .tos (creg_q[C_TOS]),
    .opc (creg_q[C_OPC]),
    .bus (b_bus)
  );

  sdp_alu #(.DW(DW), .SHAMT(IDX_SH)) u_alu (
    .a    (creg_q[C_H]),
    .b    (b_bus),
    .op   (alu_op_i),
    .shl  (shl8_i),
    .y    (c_bus),
    .neg  (alu_n),
    .zero (alu_z)
  );

  // C-bus registers: next-state and enable per register, then the flop
  for (genvar g = 0; g < CW; g++) begin : g_creg
    if (g == C_MDR) begin : g_mdr
      // a C-bus write wins over a returning read word
      always_comb begin
        creg_en[g] = cwr_i[g] | rd_q;
        creg_d[g]  = cwr_i[g] ? c_bus : mem_rdata_i;
      end
    end else begin : g_plain
      always_comb begin
        creg_en[g] = cwr_i[g];
        creg_d[g]  = c_bus;
      end
    end

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)          creg_q[g] <= '0;
      else if (creg_en[g])  creg_q[g] <= creg_d[g];
    end
  end

  // instruction byte register
  always_comb begin
    mbr_en = fetch_q;
    mbr_d  = prog_byte_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     mbr_q <= '0;
    else if (mbr_en) mbr_q <= mbr_d;
  end

  // strobes and flags
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      fetch_q <= 1'b0;
      n_q     <= 1'b0;
      z_q     <= 1'b0;
    end else begin
      rd_q    <= rd_i;
      wr_q    <= wr_i;
      fetch_q <= fetch_i;
      n_q     <= alu_n;
      z_q     <= alu_z;
    end
  end

  assign mem_addr_o  = creg_q[C_MAR] << WORD_SH;
  assign mem_wdata_o = creg_q[C_MDR];
  assign mem_rd_o    = rd_q;
  assign mem_wr_o    = wr_q;
  assign prog_addr_o = creg_q[C_PC];
  assign prog_rd_o   = fetch_q;
  assign n_o         = n_q;
  assign z_o         = z_q;
endmodule

// File: rtl/sdp_chk.sv
module sdp_chk
  import sdp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input logic          clk,
  input logic          rst_sn,
  input logic [CW-1:0] cwr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic          fetch_i,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [DW-1:0] prog_addr_o,
  input logic          prog_rd_o,
  input logic          n_o,
  input logic          z_o
);
  // input condition: one data access per microinstruction (R7, R8)
  a_r7_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    !(rd_i && wr_i));

  a_r7_rd_strobe: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_i |=> mem_rd_o);

  a_r8_wr_strobe: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_i |=> mem_wr_o);

  a_r9_fetch_strobe: assert property (@(posedge clk) disable iff (!rst_sn)
    fetch_i |=> prog_rd_o);

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !cwr_i[C_MAR] |=> $stable(mem_addr_o));

  a_r5_pc_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !cwr_i[C_PC] |=> $stable(prog_addr_o));

  a_r8_wdata_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cwr_i[C_MDR] && !mem_rd_o) |=> $stable(mem_wdata_o));

  a_r10_flag_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    n_o |-> !z_o);
endmodule

bind stack_dp_core sdp_chk #(.DW(DW)) chk_i (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .cwr_i       (cwr_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .fetch_i     (fetch_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .prog_addr_o (prog_addr_o),
  .prog_rd_o   (prog_rd_o),
  .n_o         (n_o),
  .z_o         (z_o)
);

// File: tb/stack_dp_core_tb.sv
module stack_dp_core_tb_top;
  localparam int CLK_NS = 20;

  localparam logic [2:0] O_ADD = 3'd0, O_SUB = 3'd1, O_AND = 3'd2, O_OR = 3'd3,
                         O_INC = 3'd4, O_DEC = 3'd5, O_ADD1 = 3'd6, O_PASS = 3'd7;
  localparam logic [8:0] M_NONE = 9'h000, M_MAR = 9'h001, M_MDR = 9'h002,
                         M_PC = 9'h004, M_SP = 9'h008, M_LV = 9'h010,
                         M_CPP = 9'h020, M_TOS = 9'h040, M_OPC = 9'h080,
                         M_H = 9'h100;
  localparam logic [3:0] Q_NONE = 4'd9;
  localparam logic [31:0] K_MEM = 32'h9C3E_5A10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bsel;
  logic [2:0]  op;
  logic        shl;
  logic [8:0]  cwr;
  logic        rd, wr, fetch;
  logic [31:0] mem_rdata;
  logic [7:0]  prog_byte;
  logic [31:0] mem_addr, mem_wdata, prog_addr;
  logic        mem_rd, mem_wr, prog_rd, n_f, z_f;

  int nchk  = 0;
  int nfail = 0;

  // model values kept by the bench
  logic [31:0] k0, h, sp, lv, cpp, tos, opc, pc, h2, s;
  logic [7:0]  mb;

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return a ^ K_MEM;
  endfunction

  function automatic logic [7:0] progfn(input logic [31:0] a);
    return a[7:0] ^ 8'hC4;
  endfunction

  assign mem_rdata = mem_rd  ? memfn(mem_addr)   : 32'h0;
  assign prog_byte = prog_rd ? progfn(prog_addr) : 8'h0;

  stack_dp_core dut_i (
    .clk (clk), .rst_n (rst_n), .bsel_i (bsel), .alu_op_i (op), .shl8_i (shl),
    .cwr_i (cwr), .rd_i (rd), .wr_i (wr), .fetch_i (fetch),
    .mem_rdata_i (mem_rdata), .prog_byte_i (prog_byte),
    .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata), .mem_rd_o (mem_rd),
    .mem_wr_o (mem_wr), .prog_addr_o (prog_addr), .prog_rd_o (prog_rd),
    .n_o (n_f), .z_o (z_f)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] b, input logic [2:0] o, input logic sh,
                      input logic [8:0] m, input logic r, input logic w, input logic f);
    bsel = b; op = o; shl = sh; cwr = m; rd = r; wr = w; fetch = f;
    @(posedge clk);
    @(negedge clk);
    bsel = Q_NONE; op = O_PASS; shl = 1'b0; cwr = M_NONE; rd = 1'b0; wr = 1'b0; fetch = 1'b0;
  endtask

  task automatic idle();
    step(Q_NONE, O_PASS, 1'b0, M_NONE, 1'b0, 1'b0, 1'b0);
  endtask

  // copy one B-bus source into the data register and read it at the port
  task automatic peek(input logic [3:0] code, output logic [31:0] v);
    step(code, O_PASS, 1'b0, M_MDR, 1'b0, 1'b0, 1'b0);
    v = mem_wdata;
  endtask

  task automatic t_reset();
    chk("R1 addr",   mem_addr, 32'h0);
    chk("R1 wdata",  mem_wdata, 32'h0);
    chk("R1 paddr",  prog_addr, 32'h0);
    chk("R1 strobes", {29'h0, mem_rd, mem_wr, prog_rd}, 32'h0);
    chk("R1 flags",  {30'h0, n_f, z_f}, 32'h0);
  endtask

  task automatic t_load_and_alu();
    logic [31:0] v;
    step(4'd0, O_PASS, 1'b0, M_NONE, 1'b1, 1'b0, 1'b0);
    chk("R7 rd strobe", {31'h0, mem_rd}, 32'h1);
    chk("R6 addr zero", mem_addr, 32'h0);
    idle();
    k0 = memfn(32'h0);
    chk("R7 rd data", mem_wdata, k0);
    chk("R7 rd strobe low", {31'h0, mem_rd}, 32'h0);
    // build distinct register values through every ALU function (R3)
    step(4'd0, O_PASS, 1'b0, M_H,   1'b0, 1'b0, 1'b0); h   = k0;
    step(4'd0, O_INC,  1'b0, M_SP,  1'b0, 1'b0, 1'b0); sp  = k0 + 32'd1;
    step(4'd0, O_DEC,  1'b0, M_LV,  1'b0, 1'b0, 1'b0); lv  = k0 - 32'd1;
    step(4'd4, O_OR,   1'b0, M_CPP, 1'b0, 1'b0, 1'b0); cpp = h | sp;
    step(4'd5, O_AND,  1'b0, M_TOS, 1'b0, 1'b0, 1'b0); tos = h & lv;
    step(4'd0, O_ADD1, 1'b0, M_OPC, 1'b0, 1'b0, 1'b0); opc = h + k0 + 32'd1;
    step(4'd4, O_SUB,  1'b0, M_PC,  1'b0, 1'b0, 1'b0); pc  = sp - h;
    chk("R3 B-H to program address", prog_addr, pc);
    peek(4'd0, v); chk("R2 code0 data reg", v, k0);
    peek(4'd1, v); chk("R2 code1 pc", v, pc);
    peek(4'd4, v); chk("R3 B+1 / R2 code4 sp", v, sp);
    peek(4'd5, v); chk("R3 B-1 / R2 code5 lv", v, lv);
    peek(4'd6, v); chk("R3 OR / R2 code6 cpp", v, cpp);
    peek(4'd7, v); chk("R3 AND / R2 code7 tos", v, tos);
    peek(4'd8, v); chk("R3 H+B+1 / R2 code8 opc", v, opc);
  endtask

  task automatic t_fetch_and_byte_views();
    logic [31:0] v;
    step(Q_NONE, O_PASS, 1'b0, M_NONE, 1'b0, 1'b0, 1'b1);
    chk("R9 fetch strobe", {31'h0, prog_rd}, 32'h1);
    chk("R9 fetch address", prog_addr, pc);
    idle();
    mb = progfn(pc);
    peek(4'd2, v); chk("R2 R9 byte sign-extended", v, {{24{mb[7]}}, mb});
    peek(4'd3, v); chk("R2 R9 byte zero-extended", v, {24'h0, mb});
    for (int c = 9; c < 16; c++) begin
      peek(4'(c), v); chk("R2 unused code is zero", v, 32'h0);
    end
  endtask

  task automatic t_shift();
    step(4'd3, O_PASS, 1'b1, M_H, 1'b0, 1'b0, 1'b0);
    step(4'd3, O_OR,   1'b0, M_H, 1'b0, 1'b0, 1'b0);
    h2 = {16'h0, mb, mb};
    step(Q_NONE, O_ADD, 1'b0, M_MDR, 1'b0, 1'b0, 1'b0);
    chk("R4 16-bit index in H", mem_wdata, h2);
    step(4'd2, O_PASS, 1'b1, M_MDR, 1'b0, 1'b0, 1'b0);
    chk("R4 shifted signed byte", mem_wdata, {{16{mb[7]}}, mb, 8'h00});
  endtask

  task automatic t_multi_write();
    logic [31:0] v;
    step(4'd4, O_DEC, 1'b0, M_MAR | M_SP, 1'b0, 1'b0, 1'b0);
    sp = sp - 32'd1;
    chk("R5 R6 address from shared result", mem_addr, sp << 2);
    step(4'd7, O_ADD, 1'b0, M_MDR | M_TOS, 1'b0, 1'b1, 1'b0);
    s = h2 + tos;
    chk("R8 wr strobe", {31'h0, mem_wr}, 32'h1);
    chk("R8 write data", mem_wdata, s);
    chk("R8 write address", mem_addr, sp << 2);
    peek(4'd7, v); chk("R5 second target tos", v, s);
    peek(4'd4, v); chk("R5 sp same result", v, sp);
    peek(4'd5, v); chk("R5 unmasked lv kept", v, lv);
    chk("R8 wr strobe low", {31'h0, mem_wr}, 32'h0);
  endtask

  task automatic t_flags();
    step(Q_NONE, O_PASS, 1'b0, M_NONE, 1'b0, 1'b0, 1'b0);
    chk("R10 zero result", {30'h0, n_f, z_f}, 32'h1);
    step(4'd5, O_PASS, 1'b0, M_NONE, 1'b0, 1'b0, 1'b0);
    chk("R10 negative result", {30'h0, n_f, z_f}, {30'h0, lv[31], 1'b0});
    step(Q_NONE, O_ADD, 1'b0, M_NONE, 1'b0, 1'b0, 1'b0);
    chk("R10 positive result", {30'h0, n_f, z_f}, 32'h0);
    step(4'd3, O_PASS, 1'b1, M_NONE, 1'b0, 1'b0, 1'b0);
    chk("R10 R4 flags after shift", {30'h0, n_f, z_f}, 32'h0);
  endtask

  task automatic t_override();
    step(Q_NONE, O_PASS, 1'b0, M_NONE, 1'b1, 1'b0, 1'b0);
    step(Q_NONE, O_INC, 1'b0, M_MDR, 1'b0, 1'b0, 1'b0);
    chk("R11 C-bus wins over read", mem_wdata, 32'h1);
    step(Q_NONE, O_PASS, 1'b0, M_NONE, 1'b1, 1'b0, 1'b0);
    idle();
    chk("R7 read at shifted address", mem_wdata, memfn(sp << 2));
  endtask

  initial begin
    rst_n = 1'b0;
    bsel = Q_NONE; op = O_PASS; shl = 1'b0; cwr = M_NONE;
    rd = 1'b0; wr = 1'b0; fetch = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_load_and_alu();
    t_fetch_and_byte_views();
    t_shift();
    t_multi_write();
    t_flags();
    t_override();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule